// File: doc/BRIEF.md
# Table-Driven Detector Clock Sequencer

This block produces the clock waveforms for an image sensor's charge-transfer phases, the two sampling windows of a digital correlated double sampler, and a strobe that marks each finished pixel. Waveforms are not encoded in state logic. They come from a timing table in on-chip memory. Each table word holds the levels of all clock lines, two window bits, a pixel-done flag and a dwell count, at a resolution of one system clock. A table can therefore hold three-phase transfers, four-phase transfers or any mix of the two. The block only changes what it emits when the table changes.

The host fills the table and a small set of configuration registers while the sequencer is idle. The table holds two segments. The row segment runs once at the start of each row. The pixel segment then runs a programmed number of times. This pattern repeats for a programmed number of rows. A start pulse launches a readout. When the readout ends, the lines return to a programmed parking vector and a done flag rises. An abort pulse stops the readout early. Any write attempted during a run is dropped and raises an error flag.

Top module: `clkseq_top`

## Requirements
- R1: After reset, `clk_lines`, `win_rst`, `win_sig`, `pix_done`, `busy`, `done` and `err` are all zero, and every configuration register is zero.
- R2: Configuration writes use `reg_sel` codes 0 row-segment first address, 1 row-segment last address, 2 pixel-segment first address, 3 pixel-segment last address, 4 row count, 5 pixel repeats per row, and 6 parking vector. Code 7 is ignored. While idle, `clk_lines` shows the parking vector by the second rising edge after the write.
- R3: In a table word, bits [NLINES-1:0] are the line levels, bit NLINES is the reset window, bit NLINES+1 is the signal window, bit NLINES+2 is the pixel-done flag, and the top DWELL_W bits are the dwell D. Outputs take a word's values at the edge on which the word is reached, and hold them for D+1 cycles.
- R4: `pix_done` is high only in the first cycle of a word whose flag is set.
- R5: A start accepted while idle makes the first word of the row segment appear at the next edge. Each row runs the row segment once, from its first to its last address, and then runs the pixel segment its repeat count times. Addresses step upward modulo the table depth.
- R6: A row count or a pixel repeat count of 0 behaves as 1.
- R7: On the edge after the last cycle of the last word, `busy` falls, `done` rises and `clk_lines` shows the parking vector. `done` stays high until the next accepted start.
- R8: `abort` during a run puts the parking vector on `clk_lines` at the next edge. At the same edge it clears the windows, the strobe and `busy`, and it leaves `done` low.
- R9: A table or configuration write while `busy` is high changes nothing and sets `err`. `err` stays set until the next accepted start clears it.
- R10: `start` while `busy` is high has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one timing step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a readout, accepted only when idle |
| abort | input | 1 | Stop a running readout |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | ADDR_W | Table write address |
| tbl_wdata | input | NLINES+3+DWELL_W | Table word to write |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 3 | Configuration register code |
| reg_wdata | input | NLINES | Configuration value; addresses and counts use the low bits |
| clk_lines | output | NLINES | Detector clock line levels |
| win_rst | output | 1 | Reset-level sampling window |
| win_sig | output | 1 | Signal-level sampling window |
| pix_done | output | 1 | Pixel finished strobe |
| busy | output | 1 | Readout in progress |
| done | output | 1 | Last readout completed normally |
| err | output | 1 | A write was attempted during a run |

## Verification
The bench builds the block with 20 clock lines, a 32-word table, 8-bit repeat counters and 16-bit dwells. With only 32 words, a pixel segment that runs from address 30 through 1 exercises address wrap. The 16-bit dwell allows one word to hold for 301 cycles, so long holds are covered while the run stays short. Separate three-phase and four-phase tables, one of them with a zero repeat count, are compared cycle by cycle against a sequence the bench rebuilds from its own copy of the table.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [2:0] {
    SEL_ROW_FIRST = 3'd0,
    SEL_ROW_LAST  = 3'd1,
    SEL_PIX_FIRST = 3'd2,
    SEL_PIX_LAST  = 3'd3,
    SEL_ROW_REPS  = 3'd4,
    SEL_PIX_REPS  = 3'd5,
    SEL_PARK      = 3'd6
  } cfg_sel_e;

  // A programmed count of zero still runs its segment once.
  function automatic int unsigned reps_eff(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/clkseq_table.sv
module clkseq_table #(
  parameter int ADDR_W = 6,
  parameter int ENT_W  = 39
) (
  input  logic              clk,
  input  logic              busy,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic             wr_ok;

  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R9: a write during a run leaves the addressed word untouched
  a_r9_table_frozen: assert property (@(posedge clk)
    (busy && we) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/clkseq_cfg.sv
module clkseq_cfg
  import clkseq_pkg::*;
#(
  parameter int NLINES = 20,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              start,
  input  logic              tbl_we,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [ADDR_W-1:0] row_first,
  output logic [ADDR_W-1:0] row_last,
  output logic [ADDR_W-1:0] pix_first,
  output logic [ADDR_W-1:0] pix_last,
  output logic [CNT_W-1:0]  row_reps,
  output logic [CNT_W-1:0]  pix_reps,
  output logic [NLINES-1:0] park_vec,
  output logic              err
);
  logic cfg_ok, bad_write, run_accept;

  assign cfg_ok     = reg_we && !busy;
  assign bad_write  = busy && (reg_we || tbl_we);
  assign run_accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_first <= '0;
      row_last  <= '0;
      pix_first <= '0;
      pix_last  <= '0;
      row_reps  <= '0;
      pix_reps  <= '0;
      park_vec  <= '0;
    end else if (cfg_ok) begin
      case (reg_sel)
        SEL_ROW_FIRST: row_first <= reg_wdata[ADDR_W-1:0];
        SEL_ROW_LAST:  row_last  <= reg_wdata[ADDR_W-1:0];
        SEL_PIX_FIRST: pix_first <= reg_wdata[ADDR_W-1:0];
        SEL_PIX_LAST:  pix_last  <= reg_wdata[ADDR_W-1:0];
        SEL_ROW_REPS:  row_reps  <= reg_wdata[CNT_W-1:0];
        SEL_PIX_REPS:  pix_reps  <= reg_wdata[CNT_W-1:0];
        SEL_PARK:      park_vec  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          err <= 1'b0;
    else if (bad_write)  err <= 1'b1;
    else if (run_accept) err <= 1'b0;
  end

  // R9: configuration cannot move while a run is in progress
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(park_vec) && $stable(row_reps) && $stable(pix_reps)
              && $stable(row_first) && $stable(pix_first)));

  // R9: an attempted write during a run raises the error flag
  a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |=> err);

endmodule

// File: rtl/clkseq_walker.sv
module clkseq_walker
  import clkseq_pkg::*;
#(
  parameter int NLINES  = 20,
  parameter int ADDR_W  = 6,
  parameter int CNT_W   = 16,
  parameter int DWELL_W = 16,
  localparam int ENT_W  = NLINES + 3 + DWELL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] row_first,
  input  logic [ADDR_W-1:0] row_last,
  input  logic [ADDR_W-1:0] pix_first,
  input  logic [ADDR_W-1:0] pix_last,
  input  logic [CNT_W-1:0]  row_reps,
  input  logic [CNT_W-1:0]  pix_reps,
  input  logic [NLINES-1:0] park_vec,
  input  logic [ENT_W-1:0]  ent,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [NLINES-1:0] clk_lines,
  output logic              win_rst,
  output logic              win_sig,
  output logic              pix_done,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0]  addr, nxt_addr;
  logic [DWELL_W-1:0] cnt;
  logic               in_row, nxt_in_row;
  logic [CNT_W-1:0]   row_n, pix_n, nxt_row, nxt_pix;
  logic               last_word;
  int unsigned        row_tot, pix_tot;

  logic [NLINES-1:0]  ent_lines;
  logic               ent_rst, ent_sig, ent_pd;
  logic [DWELL_W-1:0] ent_dwell;

  assign ent_lines = ent[NLINES-1:0];
  assign ent_rst   = ent[NLINES];
  assign ent_sig   = ent[NLINES+1];
  assign ent_pd    = ent[NLINES+2];
  assign ent_dwell = ent[ENT_W-1:NLINES+3];

  assign row_tot = reps_eff(32'(row_reps));
  assign pix_tot = reps_eff(32'(pix_reps));

  // Named events for the checks below
  logic launch, word_end, step_load, seq_finish, seq_abort;

  always_comb begin
    nxt_addr   = addr;
    nxt_in_row = in_row;
    nxt_row    = row_n;
    nxt_pix    = pix_n;
    last_word  = 1'b0;
    if (!busy) begin
      nxt_addr   = row_first;
      nxt_in_row = 1'b1;
      nxt_row    = CNT_W'(1);
      nxt_pix    = CNT_W'(1);
    end else if (in_row) begin
      if (addr == row_last) begin
        nxt_addr   = pix_first;
        nxt_in_row = 1'b0;
      end else begin
        nxt_addr = addr + ADDR_W'(1);
      end
    end else if (addr != pix_last) begin
      nxt_addr = addr + ADDR_W'(1);
    end else if (32'(pix_n) < pix_tot) begin
      nxt_pix  = pix_n + CNT_W'(1);
      nxt_addr = pix_first;
    end else if (32'(row_n) < row_tot) begin
      nxt_row    = row_n + CNT_W'(1);
      nxt_pix    = CNT_W'(1);
      nxt_in_row = 1'b1;
      nxt_addr   = row_first;
    end else begin
      last_word = 1'b1;
    end
  end

  assign rd_addr    = nxt_addr;
  assign launch     = start && !busy;
  assign seq_abort  = busy && abort;
  assign word_end   = busy && !abort && (cnt == '0);
  assign step_load  = launch || (word_end && !last_word);
  assign seq_finish = word_end && last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      addr      <= '0;
      cnt       <= '0;
      in_row    <= 1'b0;
      row_n     <= '0;
      pix_n     <= '0;
      clk_lines <= '0;
      win_rst   <= 1'b0;
      win_sig   <= 1'b0;
      pix_done  <= 1'b0;
    end else if (seq_abort) begin
      busy      <= 1'b0;
      clk_lines <= park_vec;
      win_rst   <= 1'b0;
      win_sig   <= 1'b0;
      pix_done  <= 1'b0;
    end else if (step_load) begin
      if (launch) done <= 1'b0;
      busy      <= 1'b1;
      addr      <= nxt_addr;
      in_row    <= nxt_in_row;
      row_n     <= nxt_row;
      pix_n     <= nxt_pix;
      cnt       <= ent_dwell;
      clk_lines <= ent_lines;
      win_rst   <= ent_rst;
      win_sig   <= ent_sig;
      pix_done  <= ent_pd;
    end else if (seq_finish) begin
      busy      <= 1'b0;
      done      <= 1'b1;
      clk_lines <= park_vec;
      win_rst   <= 1'b0;
      win_sig   <= 1'b0;
      pix_done  <= 1'b0;
    end else if (busy) begin
      cnt      <= cnt - DWELL_W'(1);
      pix_done <= 1'b0;
    end else begin
      clk_lines <= park_vec;
    end
  end

  // R3: a word holds its outputs while its dwell is still counting
  a_r3_dwell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && cnt != '0) |=>
      ($stable(clk_lines) && $stable(win_rst) && $stable(win_sig) && busy));

  // R4: the pixel strobe only appears during a run
  a_r4_strobe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    pix_done |-> busy);

  // R7: completion parks the lines and flags done
  a_r7_finish_parks: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> (done && !busy && clk_lines == $past(park_vec)));

  // R7: done never coexists with a run
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: abort parks within one clock without signalling done
  a_r8_abort_parks: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (!busy && !done && !win_rst && !win_sig && !pix_done
                   && clk_lines == $past(park_vec)));

  // R10: a start during a run does not disturb the walk
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !abort && cnt != '0) |=> (busy && $stable(addr)));

endmodule

// File: rtl/clkseq_top.sv
module clkseq_top #(
  parameter int NLINES  = 20,
  parameter int ADDR_W  = 6,
  parameter int CNT_W   = 16,
  parameter int DWELL_W = 16,
  localparam int ENT_W  = NLINES + 3 + DWELL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0]  tbl_wdata,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] clk_lines,
  output logic              win_rst,
  output logic              win_sig,
  output logic              pix_done,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] row_first, row_last, pix_first, pix_last, rd_addr;
  logic [CNT_W-1:0]  row_reps, pix_reps;
  logic [NLINES-1:0] park_vec;
  logic [ENT_W-1:0]  ent;

  clkseq_table #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_table (
    .clk(clk), .busy(busy), .we(tbl_we), .waddr(tbl_addr),
    .wdata(tbl_wdata), .raddr(rd_addr), .rdata(ent)
  );

  clkseq_cfg #(.NLINES(NLINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .tbl_we(tbl_we),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .row_first(row_first), .row_last(row_last), .pix_first(pix_first),
    .pix_last(pix_last), .row_reps(row_reps), .pix_reps(pix_reps),
    .park_vec(park_vec), .err(err)
  );

  clkseq_walker #(.NLINES(NLINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
                  .DWELL_W(DWELL_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .row_first(row_first), .row_last(row_last), .pix_first(pix_first),
    .pix_last(pix_last), .row_reps(row_reps), .pix_reps(pix_reps),
    .park_vec(park_vec), .ent(ent), .rd_addr(rd_addr),
    .clk_lines(clk_lines), .win_rst(win_rst), .win_sig(win_sig),
    .pix_done(pix_done), .busy(busy), .done(done)
  );

endmodule

// File: tb/clkseq_top_test.sv
`timescale 1ns/1ps
module clkseq_top_test;
  localparam int NL = 20, AW = 5, CW = 8, DW = 16;
  localparam int EW = NL + 3 + DW;
  localparam int DEPTH = 1 << AW;
  localparam int MAXE = 4096;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic tbl_we = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [EW-1:0] tbl_wdata = '0;
  logic [2:0]    reg_sel = '0;
  logic [NL-1:0] reg_wdata = '0;
  logic [NL-1:0] clk_lines;
  logic win_rst, win_sig, pix_done, busy, done, err;

  clkseq_top #(.NLINES(NL), .ADDR_W(AW), .CNT_W(CW), .DWELL_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .clk_lines(clk_lines), .win_rst(win_rst), .win_sig(win_sig),
    .pix_done(pix_done), .busy(busy), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;

  // Bench copy of table and configuration
  logic [NL-1:0] b_lines [DEPTH];
  logic          b_rst [DEPTH], b_sig [DEPTH], b_pd [DEPTH];
  int            b_dw [DEPTH];
  int            rf, rl, pf, pl, rr, pr;
  logic [NL-1:0] park;

  // Expected per-cycle stream
  logic [NL-1:0] e_lines [MAXE];
  logic          e_rst [MAXE], e_sig [MAXE], e_pd [MAXE];
  int            n_exp;

  task automatic chk(input bit ok, input string msg);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic wr_tbl(input int a, input logic [NL-1:0] ln, input logic r,
                        input logic s, input logic p, input int dw);
    tbl_we = 1'b1; tbl_addr = AW'(a);
    tbl_wdata = {DW'(dw), p, s, r, ln};
    @(negedge clk);
    tbl_we = 1'b0;
    b_lines[a] = ln; b_rst[a] = r; b_sig[a] = s; b_pd[a] = p; b_dw[a] = dw;
  endtask

  task automatic wr_cfg(input int sel, input logic [NL-1:0] v);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      0: rf = int'(v) % DEPTH;
      1: rl = int'(v) % DEPTH;
      2: pf = int'(v) % DEPTH;
      3: pl = int'(v) % DEPTH;
      4: rr = int'(v) % (1 << CW);
      5: pr = int'(v) % (1 << CW);
      6: park = v;
      default: ;
    endcase
  endtask

  task automatic emit(input int a);
    for (int c = 0; c <= b_dw[a]; c++) begin
      e_lines[n_exp] = b_lines[a];
      e_rst[n_exp]   = b_rst[a];
      e_sig[n_exp]   = b_sig[a];
      e_pd[n_exp]    = b_pd[a] && (c == 0);
      n_exp++;
    end
  endtask

  task automatic walk_seg(input int first, input int last);
    int a;
    a = first;
    forever begin
      emit(a);
      if (a == last) break;
      a = (a + 1) % DEPTH;
    end
  endtask

  task automatic build_exp();
    int rows, pixs;
    n_exp = 0;
    rows = (rr == 0) ? 1 : rr;
    pixs = (pr == 0) ? 1 : pr;
    for (int r = 0; r < rows; r++) begin
      walk_seg(rf, rl);
      for (int p = 0; p < pixs; p++) walk_seg(pf, pl);
    end
  endtask

  // Launch, compare every cycle, then check the completion cycle.
  // inject=1 attempts writes and a second start mid-run.
  task automatic run_stream(input string tag, input bit inject);
    bit bad;
    string first;
    bad = 1'b0; first = "";
    build_exp();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n_exp; i++) begin
      if (!bad && (clk_lines !== e_lines[i] || win_rst !== e_rst[i] ||
                   win_sig !== e_sig[i] || pix_done !== e_pd[i] || busy !== 1'b1)) begin
        bad = 1'b1;
        first = $sformatf("cycle %0d lines=%h/%b/%b/%b busy=%b exp %h/%b/%b/%b busy=1",
                          i, clk_lines, win_rst, win_sig, pix_done, busy,
                          e_lines[i], e_rst[i], e_sig[i], e_pd[i]);
      end
      if (inject) begin
        if (i == 2) begin
          tbl_we = 1'b1; tbl_addr = AW'(pf); tbl_wdata = '1;
          reg_we = 1'b1; reg_sel = 3'd6; reg_wdata = ~park;
        end
        if (i == 3) begin tbl_we = 1'b0; reg_we = 1'b0; end
        if (i == 4) start = 1'b1;
        if (i == 5) start = 1'b0;
      end
      @(negedge clk);
    end
    chk(!bad, $sformatf("%s stream mismatch: %s", tag, first));
    chk(busy == 1'b0 && done == 1'b1 && clk_lines == park,
        $sformatf("R7 %s end: busy=%b done=%b lines=%h exp 0/1/%h",
                  tag, busy, done, clk_lines, park));
  endtask

  task automatic t_reset();
    chk(clk_lines == '0 && !win_rst && !win_sig && !pix_done && !busy && !done && !err,
        $sformatf("R1 reset: lines=%h w=%b%b pd=%b busy=%b done=%b err=%b exp all 0",
                  clk_lines, win_rst, win_sig, pix_done, busy, done, err));
  endtask

  task automatic t_park();
    wr_cfg(6, 20'h5_A0C3);
    @(negedge clk);
    chk(clk_lines == 20'h5_A0C3,
        $sformatf("R2 park follow: lines=%h exp 5a0c3", clk_lines));
    reg_we = 1'b1; reg_sel = 3'd7; reg_wdata = '1;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    chk(clk_lines == 20'h5_A0C3,
        $sformatf("R2 code 7 ignored: lines=%h exp 5a0c3", clk_lines));
  endtask

  task automatic load_three_phase();
    wr_tbl(12, 20'h00008, 0, 0, 0, 2);
    wr_tbl(13, 20'h00018, 0, 0, 0, 300);
    wr_tbl(14, 20'h00010, 0, 0, 0, 1);
    wr_tbl(4,  20'h00041, 0, 0, 0, 1);
    wr_tbl(5,  20'h00001, 1, 0, 0, 3);
    wr_tbl(6,  20'h00002, 0, 0, 0, 0);
    wr_tbl(7,  20'h00004, 0, 1, 1, 3);
    wr_cfg(0, 12); wr_cfg(1, 14); wr_cfg(2, 4); wr_cfg(3, 7);
    wr_cfg(4, 2);  wr_cfg(5, 3);
  endtask

  task automatic t_three_phase();
    load_three_phase();
    run_stream("R3 R4 R5 three-phase", 1'b0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0,
        $sformatf("R7 done sticky: done=%b busy=%b exp 1/0", done, busy));
  endtask

  task automatic t_four_phase();
    wr_tbl(16, 20'h00100, 0, 0, 0, 1);
    wr_tbl(17, 20'h00300, 0, 0, 0, 1);
    wr_tbl(18, 20'h00200, 0, 0, 0, 1);
    wr_tbl(19, 20'h00600, 0, 0, 0, 1);
    wr_tbl(30, 20'h03000, 1, 0, 0, 2);
    wr_tbl(31, 20'h06000, 0, 0, 1, 0);
    wr_tbl(0,  20'h0C000, 0, 1, 1, 0);
    wr_tbl(1,  20'h09000, 0, 1, 0, 4);
    wr_cfg(0, 16); wr_cfg(1, 19); wr_cfg(2, 30); wr_cfg(3, 1);
    wr_cfg(4, 2);  wr_cfg(5, 0);
    run_stream("R5 R6 four-phase wrap, zero pixel count", 1'b0);
  endtask

  task automatic t_abort();
    load_three_phase();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0,
        $sformatf("R8 pre-abort: busy=%b done=%b exp 1/0", busy, done));
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(clk_lines == park && !busy && !done && !win_rst && !win_sig && !pix_done,
        $sformatf("R8 abort: lines=%h busy=%b done=%b exp %h/0/0",
                  clk_lines, busy, done, park));
    repeat (4) @(negedge clk);
    chk(clk_lines == park && !busy,
        $sformatf("R8 stays parked: lines=%h busy=%b exp %h/0", clk_lines, busy, park));
  endtask

  task automatic t_busy_writes();
    load_three_phase();
    run_stream("R9 R10 writes and start mid-run", 1'b1);
    chk(err == 1'b1, $sformatf("R9 err set: err=%b exp 1", err));
    run_stream("R9 table unchanged after ignored write", 1'b0);
    chk(err == 1'b0, $sformatf("R9 err cleared by start: err=%b exp 0", err));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rf = 0; rl = 0; pf = 0; pl = 0; rr = 0; pr = 0; park = '0;
    t_reset();
    t_park();
    t_three_phase();
    t_four_phase();
    t_abort();
    t_busy_writes();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule